// File: doc/BRIEF.md
# BT.656 Output Stream Encoder

This block turns a stream of 4:2:2 video bytes (ordered Cb, Y, Cr, Y) into an 8-bit BT.656 bus. An internal byte sequencer builds every line. Each line starts with an end-of-active-video code and continues with horizontal blanking filler. A start-of-active-video code follows, and then the active samples. Each line's field and vertical-blanking state is taken from the `field` and `vblank` inputs at the first byte of that line. The block pulls one source byte on `vid_take` for every active byte it places on the bus. Lines inside vertical blanking carry filler in place of picture data.

The bus can run at the standard byte rate, where it advances on every second clock (27 MHz from a 54 MHz clock). It can also run in a double-scan mode, where it advances on every clock and so doubles every rate. An option flips the sign of the chroma samples. A shared two-bit enable rule decides whether the companion input decoder or this encoder owns the port. Horizontal and vertical blanking levels stay available on separate pins.

Top module: `bt656_encoder`

## Requirements
- R1: `dec_en` equals `in_en`. The encoder is active only when `out_en` is 1 and `in_en` is 0. When both are 1, the input path wins and the encoder stays off.
- R2: While the encoder is inactive, from the next clock edge on, `dout` holds 10h, `hsync` and `vsync` are 0, and `vid_take` is 0.
- R3: A line is `8 + HBLANK + 2*ACT_PIX` bytes long, counted from byte 0. Bytes 0..3 are FF, 00, 00, XY. Bytes 4..3+HBLANK are blanking. Bytes 4+HBLANK..7+HBLANK are FF, 00, 00, XY. The active samples follow. The default ACT_PIX is 720.
- R4: The XY byte holds, from bit 7 down to bit 0: 1, F, V, H, V^H, F^H, F^V, F^V^H. H is 1 in the code at byte 3 and 0 in the code at byte 7+HBLANK. F and V are `field` and `vblank` as sampled when byte 0 of the line is issued.
- R5: Horizontal blanking carries 80h at even offsets from its first byte and 10h at odd offsets. On a line with V=1, the active region carries the same 80h/10h pattern and `vid_take` stays 0.
- R6: On a line with V=0, each active byte comes from `vid_byte` in the clock cycle where `vid_take` is 1. Its value is clipped to 01h..FEh, so that 00h maps to 01h and FFh maps to FEh.
- R7: With `chroma_inv` set, active bytes at even offsets (chroma) become (256 - x) mod 256 before clipping. Odd-offset (luma) bytes are unchanged.
- R8: With `dbl_scan` at 0, the bus changes to a new byte every second clock and holds each byte for two clocks. With `dbl_scan` at 1, it issues one byte per clock.
- R9: `hsync` is 1 while the byte on the bus lies in bytes 0..7+HBLANK. `vsync` equals the line's V. Both are updated together with `dout`.
- R10: After the encoder becomes active, its first byte on the bus is byte 0 (FF) of a new line, including after a disable part-way through a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (54 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_en | input | 1 | Input decoder enable request |
| out_en | input | 1 | Output encoder enable request |
| dbl_scan | input | 1 | 1 = one byte per clock, 0 = one byte per two clocks |
| chroma_inv | input | 1 | Invert chroma sign in active data |
| field | input | 1 | Field bit for the next line |
| vblank | input | 1 | Vertical blanking for the next line |
| vid_byte | input | 8 | Source sample byte (Cb, Y, Cr, Y order) |
| vid_take | output | 1 | `vid_byte` is consumed at this clock edge |
| dec_en | output | 1 | Input decoder enabled |
| dout | output | 8 | BT.656 bus |
| hsync | output | 1 | Horizontal blanking level |
| vsync | output | 1 | Vertical blanking level |

## Verification
In double-scan mode, byte n of a line appears on `dout` one clock after the first edge that sees the encoder enabled, plus n clocks. In standard mode it appears 2n+2 edges after that point and then holds for one more edge. The checks therefore wait for a fixed number of edges and sample each result at the falling edge. In standard mode they sample each byte twice, once at each of its two clocks. `vid_take` is combinational and refers to the byte that the next edge will issue, so it is counted at the same falling edges and compared against twice ACT_PIX for each picture line. Disable and enable-table effects are checked one edge after the change.

// File: rtl/bt656_encoder.sv
module bt656_encoder #(
  parameter int ACT_PIX = 720,
  parameter int HBLANK  = 268
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_en,
  input  logic       out_en,
  input  logic       dbl_scan,
  input  logic       chroma_inv,
  input  logic       field,
  input  logic       vblank,
  input  logic [7:0] vid_byte,
  output logic       vid_take,
  output logic       dec_en,
  output logic [7:0] dout,
  output logic       hsync,
  output logic       vsync
);
  localparam int LINE_BYTES = 8 + HBLANK + 2 * ACT_PIX;
  localparam int CW         = $clog2(LINE_BYTES);
  localparam logic [CW-1:0] SAV_POS  = CW'(4 + HBLANK);
  localparam logic [CW-1:0] ACT_POS  = CW'(8 + HBLANK);
  localparam logic [CW-1:0] LAST_POS = CW'(LINE_BYTES - 1);
  localparam logic [7:0] IDLE = 8'h10;

  logic [CW-1:0] hc, sav_off, blk_off, act_off;
  logic phase, f_q, v_q;
  logic enc_en, tick, in_eav, in_sav, in_act, h_bit;
  logic [7:0] xy, chroma_val, raw, clipped, nxt;

  assign dec_en  = in_en;
  assign enc_en  = out_en & ~in_en;
  assign tick    = enc_en & (dbl_scan | phase);

  assign in_eav  = hc < CW'(4);
  assign in_sav  = (hc >= SAV_POS) && (hc < ACT_POS);
  assign in_act  = hc >= ACT_POS;
  assign sav_off = hc - SAV_POS;
  assign blk_off = hc - CW'(4);
  assign act_off = hc - ACT_POS;

  assign h_bit = in_eav;
  assign xy = {1'b1, f_q, v_q, h_bit, v_q ^ h_bit, f_q ^ h_bit, f_q ^ v_q, f_q ^ v_q ^ h_bit};

  assign chroma_val = chroma_inv ? (8'd0 - vid_byte) : vid_byte;
  assign raw        = act_off[0] ? vid_byte : chroma_val;
  assign clipped    = (raw == 8'h00) ? 8'h01 : (raw == 8'hFF) ? 8'hFE : raw;

  assign vid_take = tick & in_act & ~v_q;

  always_comb begin
    if (in_eav || in_sav) begin
      case (in_eav ? hc[1:0] : sav_off[1:0])
        2'd0:    nxt = 8'hFF;
        2'd3:    nxt = xy;
        default: nxt = 8'h00;
      endcase
    end else if (!in_act) begin
      nxt = blk_off[0] ? 8'h10 : 8'h80;
    end else if (v_q) begin
      nxt = act_off[0] ? 8'h10 : 8'h80;
    end else begin
      nxt = clipped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enc_en) begin
      hc    <= '0;
      phase <= 1'b0;
      dout  <= IDLE;
      hsync <= 1'b0;
      vsync <= 1'b0;
      if (!rst_n) begin
        f_q <= 1'b0;
        v_q <= 1'b0;
      end
    end else begin
      phase <= ~phase;
      if (tick) begin
        dout  <= nxt;
        hsync <= ~in_act;
        vsync <= (hc == '0) ? vblank : v_q;
        if (hc == '0) begin
          f_q <= field;
          v_q <= vblank;
        end
        hc <= (hc == LAST_POS) ? '0 : hc + CW'(1);
      end
    end
  end
endmodule

module bt656_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_en,
  input logic       out_en,
  input logic       dbl_scan,
  input logic [7:0] vid_byte,
  input logic       vid_take,
  input logic [7:0] dout,
  input logic       hsync,
  input logic       vsync
);
  // R1
  input_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_en |=> (dout == 8'h10 && !hsync));

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> (dout == 8'h10 && !hsync && !vsync));

  // R2
  no_take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en || !out_en) |-> !vid_take);

  // R6
  clip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_take && vid_byte == 8'h00) |=> dout == 8'h01);

  // R4
  xy_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !in_en && dbl_scan && $past(dbl_scan) && $past(dbl_scan, 2) &&
     $past(dout, 2) == 8'hFF && $past(dout) == 8'h00 && dout == 8'h00)
    |=> (dout[7] && dout[3] == (dout[5] ^ dout[4]) && dout[2] == (dout[6] ^ dout[4]) &&
         dout[1] == (dout[6] ^ dout[5]) && dout[0] == (dout[6] ^ dout[5] ^ dout[4])));
endmodule

bind bt656_encoder bt656_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_en(in_en), .out_en(out_en), .dbl_scan(dbl_scan),
  .vid_byte(vid_byte), .vid_take(vid_take), .dout(dout), .hsync(hsync), .vsync(vsync)
);

// File: tb/bt656_encoder_bench.sv
module bt656_encoder_bench;
  localparam int ACT = 4;
  localparam int HB  = 4;
  localparam int LB  = 8 + HB + 2 * ACT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_en = 1'b0, out_en = 1'b0, dbl_scan = 1'b1, chroma_inv = 1'b0;
  logic field = 1'b0, vblank = 1'b0;
  logic [7:0] vid_byte = 8'h00;
  logic vid_take, dec_en, hsync, vsync;
  logic [7:0] dout;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bt656_encoder #(.ACT_PIX(ACT), .HBLANK(HB)) u_bt656_encoder (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .out_en(out_en), .dbl_scan(dbl_scan),
    .chroma_inv(chroma_inv), .field(field), .vblank(vblank), .vid_byte(vid_byte),
    .vid_take(vid_take), .dec_en(dec_en), .dout(dout), .hsync(hsync), .vsync(vsync));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xy_of(bit f, bit v, bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] exp_byte(int n, bit f, bit v, logic [7:0] vb, bit inv);
    int off;
    logic [7:0] x;
    if (n < 4 || (n >= 4 + HB && n < 8 + HB)) begin
      off = (n < 4) ? n : n - (4 + HB);
      if (off == 0) return 8'hFF;
      if (off == 3) return xy_of(f, v, n < 4);
      return 8'h00;
    end
    if (n < 4 + HB) return ((n - 4) % 2 == 0) ? 8'h80 : 8'h10;
    off = n - (8 + HB);
    if (v) return (off % 2 == 0) ? 8'h80 : 8'h10;
    x = (off % 2 == 0 && inv) ? 8'(9'd256 - {1'b0, vb}) : vb;
    if (x == 8'h00) return 8'h01;
    if (x == 8'hFF) return 8'hFE;
    return x;
  endfunction

  task automatic go_idle();
    @(negedge clk);
    out_en = 1'b0;
    in_en  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 idle dout", dout, 8'h10);
    chk("R2 idle hsync", hsync, 0);
  endtask

  task automatic run_line(string req, bit dbl, bit f, bit v, logic [7:0] vb, bit inv);
    int takes = 0;
    go_idle();
    dbl_scan = dbl; field = f; vblank = v; vid_byte = vb; chroma_inv = inv;
    out_en = 1'b1;
    if (!dbl) @(posedge clk);
    for (int n = 0; n < LB; n++) begin
      @(posedge clk);
      @(negedge clk);
      chk({req, " R3 byte"}, dout, exp_byte(n, f, v, vb, inv));
      chk({req, " R9 hsync"}, hsync, (n < 8 + HB) ? 1 : 0);
      chk({req, " R9 vsync"}, vsync, v);
      if (dbl) takes += vid_take;
      else begin
        chk({req, " R8 no take off-tick"}, vid_take, 0);
        @(posedge clk);
        @(negedge clk);
        chk({req, " R8 hold"}, dout, exp_byte(n, f, v, vb, inv));
        takes += vid_take;
      end
    end
    chk({req, " R6 R5 take count"}, takes, v ? 0 : 2 * ACT);
  endtask

  task automatic t_reset();
    chk("R2 reset dout", dout, 8'h10);
    chk("R2 reset hsync", hsync, 0);
    chk("R2 reset vsync", vsync, 0);
    chk("R2 reset take", vid_take, 0);
    chk("R1 reset dec_en", dec_en, 0);
  endtask

  task automatic t_codes();
    for (int k = 0; k < 4; k++)
      run_line("R4 codes", 1'b1, k[1], k[0], 8'h55, 1'b0);
  endtask

  task automatic t_vblank();
    run_line("R5 vblank line", 1'b1, 1'b1, 1'b1, 8'h42, 1'b0);
  endtask

  task automatic t_clip();
    run_line("R6 clip low", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    run_line("R6 clip high", 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0);
  endtask

  task automatic t_inv();
    run_line("R7 invert 90", 1'b1, 1'b0, 1'b0, 8'h90, 1'b1);
    run_line("R7 invert 01", 1'b1, 1'b0, 1'b0, 8'h01, 1'b1);
  endtask

  task automatic t_std_rate();
    run_line("R8 standard", 1'b0, 1'b1, 1'b0, 8'h33, 1'b0);
  endtask

  task automatic t_enable_table();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_en = k[1]; out_en = k[0]; dbl_scan = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 dec_en", dec_en, k[1]);
      chk("R1 encoder bus", dout, (k == 1) ? 8'hFF : 8'h10);
      out_en = 1'b0; in_en = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic t_restart();
    go_idle();
    dbl_scan = 1'b1; field = 1'b0; vblank = 1'b0; vid_byte = 8'h20;
    out_en = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    out_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 mid-line disable", dout, 8'h10);
    out_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 restart byte0", dout, 8'hFF);
    @(posedge clk);
    @(negedge clk);
    chk("R10 restart byte1", dout, 8'h00);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_codes();
    t_vblank();
    t_clip();
    t_inv();
    t_std_rate();
    t_enable_table();
    t_restart();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule